// File: doc/BRIEF.md
# Shared Split DMA FIFO

This block holds one 64-byte store, arranged as sixteen 32-bit levels, that is shared by two storage channels. An 8-bit configuration byte decides how the levels are divided: all to channel 0, eight to each channel, or all to channel 1. Each channel then runs as its own circular FIFO inside its slice of the store. It has its own push and pop ports, an occupancy count, a sticky error bit and a DMA service request.

Each channel's request rises when its fill reaches a coded fraction of its slice. A channel that owns no levels shows itself as DMA-disabled and never requests service. Two flush sources act on each channel. An interrupt with the read-flush enable set empties the slice at once. With the end-of-sector enable set, each completed sector of pushed bytes forces the request on until the slice has been drained.

Top module: `split_dma_fifo`

## Requirements
- R1: Configuration bits 6:5 set the split. Code 00 gives channel 0 all 16 levels and channel 1 none. Codes 01 and 10 give each channel 8 levels. Code 11 gives channel 1 all 16 levels and channel 0 none. A channel with no levels drives its dma_off bit high. After reset the configuration byte is 0x2A.
- R2: Channel 0's threshold code is in configuration bits 3:2 and channel 1's is in bits 1:0. Codes 00, 01, 10 and 11 select the full slice, 3/4, 1/2 and 1/4 of the slice, rounded down and never less than one level. dma_req is high when the count is at or above that level.
- R3: A channel with no levels never raises dma_req, and any push to it sets its error bit.
- R4: Configuration bits 7 and 4 keep their value across every write.
- R5: A write that changes the split is accepted only when both channels are empty. The accepted write resets both channels' pointers and counts. If the split is refused, the threshold fields of that write are still taken.
- R6: Each channel returns its words in push order on pop_data, which shows the oldest word whenever the count is non-zero. The two channels never disturb each other's contents.
- R7: When a channel's irq and rdflush_en bits are both high, its slice is emptied on that clock edge. A push or pop on that channel in the same cycle is dropped.
- R8: With eos_en set, a push that brings the channel's pushed byte total (4 bytes per push) up to its sect_len restarts that total. It also forces dma_req high while the count is non-zero. The forced request ends once the channel has been seen empty. A sect_len of 0 disables sector counting.
- R9: A push to a full channel and a pop from an empty channel are ignored. Either one sets that channel's error bit, which stays set until reset.
- R10: A push and a pop on the same channel in one cycle are both judged against the count before that edge. When both are accepted, the count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Current configuration byte |
| push | input | 2 | Push strobe per channel |
| push_data | input | 64 | Push word, channel c in bits c*32 +: 32 |
| pop | input | 2 | Pop strobe per channel |
| pop_data | output | 64 | Oldest word per channel, same packing |
| level | output | 10 | Occupancy per channel, channel c in bits c*5 +: 5 |
| dma_req | output | 2 | DMA service request per channel |
| dma_off | output | 2 | Channel owns no levels |
| err | output | 2 | Sticky overflow/underflow flag per channel |
| irq | input | 2 | Channel interrupt |
| rdflush_en | input | 2 | Read flush on interrupt enable |
| eos_en | input | 2 | End-of-sector drain enable |
| sect_len | input | 24 | Sector byte length, channel c in bits c*12 +: 12 |

## Verification
Two events can land on the same channel in the same cycle. One is a flush from irq, or a repartition, arriving with a push or pop. The other is a push and a pop together, including at a full or empty channel. Directed steps set up each collision once: a push under irq with the flush enabled, push plus pop on a half-filled channel, and a split change tried while a slice holds data. A long random phase then raises irq and configuration writes while traffic is heavy. A behavioural queue model decides the result of every collision from the requirements alone and is compared with count, request, error and data on every clock.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  // Levels owned by channel ch for split code split.
  function automatic int part_size(int levels, logic [1:0] split, bit ch);
    case (split)
      2'b00:   return ch ? 0 : levels;
      2'b11:   return ch ? levels : 0;
      default: return levels / 2;
    endcase
  endfunction

  // Request level for a slice of size levels under a 2-bit threshold code.
  function automatic int thr_levels(int size, logic [1:0] code);
    int t;
    t = (size * (4 - int'(code))) / 4;
    if (t < 1) t = 1;
    return t;
  endfunction

endpackage

// File: rtl/sdf_store.sv
module sdf_store #(
  parameter int LEVELS = 16,
  parameter int WIDTH  = 32,
  parameter int AW     = 4,
  parameter int PORTS  = 2
) (
  input  logic                   clk,
  input  logic [PORTS-1:0]       we,
  input  logic [PORTS*AW-1:0]    waddr,
  input  logic [PORTS*WIDTH-1:0] wdata,
  input  logic [PORTS*AW-1:0]    raddr,
  output logic [PORTS*WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [LEVELS];

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (we[p]) mem[waddr[p*AW +: AW]] <= wdata[p*WIDTH +: WIDTH];
    end
  end

  for (genvar g = 0; g < PORTS; g++) begin : g_rd
    assign rdata[g*WIDTH +: WIDTH] = mem[raddr[g*AW +: AW]];
  end
endmodule

// File: rtl/sdf_chan.sv
module sdf_chan
  import sdf_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 5,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] size,
  input  logic [AW-1:0] base,
  input  logic [1:0]    thr_code,
  input  logic          repart,
  input  logic          push,
  input  logic          pop,
  input  logic          flush_req,
  input  logic          eos_en,
  input  logic [SW-1:0] sect_len,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic          dreq,
  output logic          dma_off,
  output logic          err
);
  logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
  logic [CW-1:0] cnt, thr;
  logic [SW:0]   sect, sect_nxt;
  logic          drain, err_q;
  // named internal events
  logic flush_now, full, empty, push_ok, pop_ok, bad_op, boundary;

  assign flush_now = repart | flush_req;
  assign full      = (cnt == size);
  assign empty     = (cnt == '0);
  assign push_ok   = push & ~full  & ~flush_now;
  assign pop_ok    = pop  & ~empty & ~flush_now;
  assign bad_op    = ~flush_now & ((push & full) | (pop & empty));
  assign sect_nxt  = sect + (SW+1)'(4);
  assign boundary  = push_ok && (sect_len != '0) && (sect_nxt >= {1'b0, sect_len});

  assign wptr_nx = ({1'b0, wptr} + CW'(1) == size) ? '0 : wptr + AW'(1);
  assign rptr_nx = ({1'b0, rptr} + CW'(1) == size) ? '0 : rptr + AW'(1);
  assign thr     = CW'(thr_levels(int'(size), thr_code));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      sect  <= '0;
      drain <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= err_q | bad_op;
      if (flush_now) begin
        wptr  <= '0;
        rptr  <= '0;
        cnt   <= '0;
        sect  <= '0;
        drain <= 1'b0;
      end else begin
        if (push_ok) begin
          wptr <= wptr_nx;
          sect <= boundary ? '0 : sect_nxt;
        end
        if (pop_ok) rptr <= rptr_nx;
        cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        if (boundary && eos_en) drain <= 1'b1;
        else if (empty)         drain <= 1'b0;
      end
    end
  end

  assign wr_en   = push_ok;
  assign wr_addr = base + wptr;
  assign rd_addr = base + rptr;
  assign count   = cnt;
  assign dma_off = (size == '0);
  assign dreq    = !dma_off && ((cnt >= thr) || (drain && !empty));
  assign err     = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R9
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !flush_now) |=> err);
  // R3
  no_req_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size == '0) |-> !dreq);
  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> (count == '0));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= size);
  // R10
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(count));
endmodule

// File: rtl/split_dma_fifo.sv
module split_dma_fifo
  import sdf_pkg::*;
#(
  parameter int         LEVELS  = 16,
  parameter int         WIDTH   = 32,
  parameter int         SECT_W  = 12,
  parameter logic [7:0] CFG_RST = 8'h2A,
  localparam int        AW      = $clog2(LEVELS),
  localparam int        CW      = AW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_wdata,
  output logic [7:0]            cfg_rdata,
  input  logic [1:0]            push,
  input  logic [2*WIDTH-1:0]    push_data,
  input  logic [1:0]            pop,
  output logic [2*WIDTH-1:0]    pop_data,
  output logic [2*CW-1:0]       level,
  output logic [1:0]            dma_req,
  output logic [1:0]            dma_off,
  output logic [1:0]            err,
  input  logic [1:0]            irq,
  input  logic [1:0]            rdflush_en,
  input  logic [1:0]            eos_en,
  input  logic [2*SECT_W-1:0]   sect_len
);
  logic [7:0]    cfg_q;
  logic [1:0]    split_cur, split_new;
  logic          both_empty, split_ok, repart;
  logic [CW-1:0] sz [2];
  logic [AW-1:0] base [2];
  logic [1:0]    thr_code [2];
  logic [CW-1:0] cnt [2];
  logic [1:0]    wr_en;
  logic [2*AW-1:0] wr_addr, rd_addr;

  assign split_cur  = cfg_q[6:5];
  assign split_new  = cfg_wdata[6:5];
  assign both_empty = (cnt[0] == '0) && (cnt[1] == '0);
  assign split_ok   = (split_new == split_cur) || both_empty;
  assign repart     = cfg_we && split_ok && (split_new != split_cur);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= CFG_RST & 8'h6F;
    else if (cfg_we)
      cfg_q <= {cfg_q[7], (split_ok ? split_new : split_cur), cfg_q[4], cfg_wdata[3:0]};
  end
  assign cfg_rdata = cfg_q;

  assign sz[0]       = CW'(part_size(LEVELS, split_cur, 1'b0));
  assign sz[1]       = CW'(part_size(LEVELS, split_cur, 1'b1));
  assign base[0]     = '0;
  assign base[1]     = sz[0][AW-1:0];
  assign thr_code[0] = cfg_q[3:2];
  assign thr_code[1] = cfg_q[1:0];

  for (genvar g = 0; g < 2; g++) begin : g_ch
    sdf_chan #(.AW(AW), .CW(CW), .SW(SECT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .size      (sz[g]),
      .base      (base[g]),
      .thr_code  (thr_code[g]),
      .repart    (repart),
      .push      (push[g]),
      .pop       (pop[g]),
      .flush_req (irq[g] & rdflush_en[g]),
      .eos_en    (eos_en[g]),
      .sect_len  (sect_len[g*SECT_W +: SECT_W]),
      .wr_en     (wr_en[g]),
      .wr_addr   (wr_addr[g*AW +: AW]),
      .rd_addr   (rd_addr[g*AW +: AW]),
      .count     (cnt[g]),
      .dreq      (dma_req[g]),
      .dma_off   (dma_off[g]),
      .err       (err[g])
    );
    assign level[g*CW +: CW] = cnt[g];
  end

  sdf_store #(.LEVELS(LEVELS), .WIDTH(WIDTH), .AW(AW), .PORTS(2)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (push_data),
    .raddr (rd_addr),
    .rdata (pop_data)
  );

  // R4
  rsvd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q[7] == $past(cfg_q[7]) && cfg_q[4] == $past(cfg_q[4])));
  // R5
  split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !split_ok) |=> $stable(cfg_q[6:5]));
  // R5
  repart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repart |=> (cnt[0] == '0 && cnt[1] == '0));
endmodule

// File: tb/split_dma_fifo_tb.sv
module split_dma_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [1:0]  push = '0, pop = '0;
  logic [63:0] push_data = '0;
  logic [63:0] pop_data;
  logic [9:0]  level;
  logic [1:0]  dma_req, dma_off, err;
  logic [1:0]  irq = '0, rdflush_en = '0, eos_en = '0;
  logic [23:0] sect_len = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  split_dma_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .level(level), .dma_req(dma_req), .dma_off(dma_off),
    .err(err), .irq(irq), .rdflush_en(rdflush_en), .eos_en(eos_en),
    .sect_len(sect_len)
  );

  // behavioural reference
  logic [31:0] q0[$], q1[$];
  logic [7:0]  mcfg = 8'h2A;
  bit          merr [2], mdrain [2];
  int          msect [2];

  function automatic int msize(int c);
    logic [1:0] s = mcfg[6:5];
    if (s == 2'b00) return (c == 0) ? 16 : 0;
    if (s == 2'b11) return (c == 1) ? 16 : 0;
    return 8;
  endfunction

  function automatic int mthr(int c);
    int quarters [4] = '{4, 3, 2, 1};
    logic [1:0] code = (c == 0) ? mcfg[3:2] : mcfg[1:0];
    int t = (msize(c) * quarters[code]) >> 2;
    return (t == 0) ? 1 : t;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chan_step(int c, bit fl, int sz, ref logic [31:0] q[$]);
    int n = q.size();
    bit bnd = 0;
    if (fl) begin
      q.delete(); msect[c] = 0; mdrain[c] = 0;
      return;
    end
    if (push[c] && n < sz) begin
      int nx = msect[c] + 4;
      q.push_back(push_data[c*32 +: 32]);
      if (sect_len[c*12 +: 12] != 0 && nx >= int'(sect_len[c*12 +: 12])) begin
        msect[c] = 0; bnd = 1;
      end else msect[c] = nx;
    end else if (push[c]) merr[c] = 1;
    if (pop[c] && n > 0) void'(q.pop_front());
    else if (pop[c]) merr[c] = 1;
    if (bnd && eos_en[c]) mdrain[c] = 1;
    else if (n == 0) mdrain[c] = 0;
  endtask

  task automatic model_update();
    bit acc = (cfg_wdata[6:5] == mcfg[6:5]) || (q0.size() == 0 && q1.size() == 0);
    bit rep = cfg_we && acc && (cfg_wdata[6:5] != mcfg[6:5]);
    int s0 = msize(0), s1 = msize(1);
    chan_step(0, rep || (irq[0] && rdflush_en[0]), s0, q0);
    chan_step(1, rep || (irq[1] && rdflush_en[1]), s1, q1);
    if (cfg_we) mcfg = {1'b0, (acc ? cfg_wdata[6:5] : mcfg[6:5]), 1'b0, cfg_wdata[3:0]};
  endtask

  task automatic compare_all();
    chk("R4 cfg", cfg_rdata, mcfg);
    for (int c = 0; c < 2; c++) begin
      int n = (c == 0) ? q0.size() : q1.size();
      bit rq = msize(c) != 0 && (n >= mthr(c) || (mdrain[c] && n != 0));
      chk("R6 level", level[c*5 +: 5], n);
      chk("R2 dma_req", dma_req[c], rq);
      chk("R1 dma_off", dma_off[c], msize(c) == 0);
      chk("R9 err", err[c], merr[c]);
      if (n > 0) chk("R6 data", pop_data[c*32 +: 32], (c == 0) ? q0[0] : q1[0]);
    end
  endtask

  task automatic cycle();
    model_update();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    push = '0; pop = '0; cfg_we = 0; irq = '0;
  endtask

  task automatic do_push(int c, logic [31:0] d);
    push[c] = 1; push_data[c*32 +: 32] = d; cycle();
  endtask

  task automatic do_cfg(logic [7:0] v);
    cfg_we = 1; cfg_wdata = v; cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R1)
    chk("R1 reset cfg", cfg_rdata, 8'h2A);
    chk("R1 reset level", level, 0);
    chk("R1 reset req", dma_req, 0);
    chk("R1 reset off", dma_off, 0);
    chk("R9 reset err", err, 0);

    // R6 order on both channels
    for (int i = 0; i < 5; i++) do_push(0, 32'hA000_0000 + i);
    for (int i = 0; i < 3; i++) do_push(1, 32'hB000_0000 + i);
    pop[0] = 1; cycle();
    chk("R6 ch0 head", pop_data[31:0], 32'hA000_0001);
    chk("R6 ch1 head", pop_data[63:32], 32'hB000_0000);

    // R10 push and pop together keep the count
    push[0] = 1; pop[0] = 1; push_data[31:0] = 32'hC0DE; cycle();
    chk("R10 same cycle", level[4:0], 4);

    // R5 refused split change while data is held, thresholds taken
    do_cfg(8'h63);
    chk("R5 split kept", cfg_rdata[6:5], 2'b01);
    chk("R5 thr taken", cfg_rdata[3:0], 4'h3);

    // empty both, then underflow (R9)
    repeat (4) begin pop[0] = 1; cycle(); end
    repeat (3) begin pop[1] = 1; cycle(); end
    pop[0] = 1; cycle();
    chk("R9 underflow", err[0], 1);

    // R5 accepted split change; R1 channel 1 off
    do_cfg(8'h0F);
    chk("R5 split taken", cfg_rdata[6:5], 2'b00);
    chk("R1 ch1 off", dma_off[1], 1);
    // R3 push to channel without levels
    do_push(1, 32'h1);
    chk("R3 err on push", err[1], 1);
    chk("R3 no req", dma_req[1], 0);

    // R2 threshold 1/4 of 16 = 4
    for (int i = 0; i < 3; i++) do_push(0, 32'h100 + i);
    chk("R2 below thr", dma_req[0], 0);
    do_push(0, 32'h103);
    chk("R2 at thr", dma_req[0], 1);

    // R1 capacity 16, overflow ignored (R9)
    for (int i = 4; i < 17; i++) do_push(0, 32'h100 + i);
    chk("R1 capacity", level[4:0], 16);

    // R7 flush wins over push
    rdflush_en = 2'b01; irq[0] = 1; push[0] = 1; push_data[31:0] = 32'hFFFF; cycle();
    chk("R7 flushed", level[4:0], 0);
    rdflush_en = '0;

    // R8 end-of-sector drain
    do_cfg(8'h20);
    eos_en = 2'b01; sect_len[11:0] = 12'd8;
    do_push(0, 32'h11); do_push(0, 32'h22);
    chk("R8 drain req", dma_req[0], 1);
    pop[0] = 1; cycle(); pop[0] = 1; cycle();
    chk("R8 empty no req", dma_req[0], 0);
    do_push(0, 32'h33);
    chk("R8 drain cleared", dma_req[0], 0);
    pop[0] = 1; cycle();

    // R4 reserved bits
    do_cfg(8'hFF);
    chk("R4 rsvd", cfg_rdata, 8'h6F);

    // random collisions
    for (int k = 0; k < 4000; k++) begin
      push = 2'($urandom);
      pop  = 2'($urandom) & 2'($urandom);
      push_data = {$urandom, $urandom};
      irq = ($urandom % 40 == 0) ? 2'($urandom) : 2'b00;
      rdflush_en = 2'($urandom);
      eos_en = 2'($urandom);
      if (k % 200 == 0) sect_len = {12'(4 * ($urandom % 6)), 12'(4 * ($urandom % 6))};
      if ($urandom % 60 == 0) begin
        cfg_we = 1; cfg_wdata = 8'($urandom);
      end
      if ($urandom % 300 == 0) begin pop = 2'b11; push = 2'b00; end
      cycle();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule